// File: doc/BRIEF.md
# Two-Stage Reboot Watchdog Timer

This block is a watchdog peripheral on a small byte-addressed register window with separate read and write strobes. A prescaler turns the core clock into a slow tick. On each tick a down-counter loses one step. When a tick arrives while the count is already zero, the counter expires and reloads from a programmed initial value. The first expiry only raises a status flag. If a second expiry follows with no software reload in between, the block raises a system reset request. That request stays high until the block itself is reset, unless a no-reboot gate was set when the second expiry happened.

Software keeps the system alive by writing any value to the reload register. It can also read the live count, program the initial value, halt or resume the timer, clear status flags, and open or close the no-reboot gate. A board strap input can force the gate to stay closed. The parameter `WIDE` selects between a narrow generation, with a 6-bit timer and an 8-bit initial-value register at offset 0x01, and a wide generation, with a 10-bit timer and a 16-bit initial-value register at offset 0x12.

The expiry tracker is a three-state machine:
- CLEAN: no expiry is pending.
- ARMED: one expiry has been seen.
- TRIPPED: a reset request is being held.

Its transitions are:
- `first_expiry`: CLEAN to ARMED.
- `second_expiry_trip`: ARMED to TRIPPED, taken when the gate is open.
- `second_expiry_gated`: ARMED to CLEAN, taken when the gate is closed.
- `reload_clear`: CLEAN or ARMED to CLEAN, on a software reload.

TRIPPED has no exit other than reset.

Top module: `dual_expiry_wdt`

## Requirements
- R1: Coming out of reset, the following hold:
  - the timer is halted (offset 0x08 reads 0x0800);
  - the count and the initial value are all ones in the timer width;
  - the no-reboot gate reads 1 at offset 0x0C bit 0;
  - both status registers read 0;
  - `reset_req` is low.
- R2: While bit 11 of offset 0x08 is 0, the count drops by one every `TICK_CYCLES` clocks. While that bit is 1, the count holds. Bit 11 reads back as written, and every other bit of 0x08 reads 0.
- R3: A read of offset 0x00 returns the live count in the low timer-width bits, with zeros above. A write of any value to 0x00 loads the count from the initial value and returns the state machine to CLEAN.
- R4: The initial value sits in the low timer-width bits of the init register:
  - the narrow generation uses offset 0x01, 8 bits wide;
  - the wide generation uses offset 0x12, 16 bits wide.

  The bits above the timer field are stored and read back as written. A write whose timer field is 0 to 3 leaves the initial value unchanged.
- R5: A tick that finds the count at zero is an expiry, and it reloads the count from the initial value. An expiry in CLEAN sets bit 3 of offset 0x04 and does not request a reset.
- R6: An expiry in ARMED sets bit 1 of offset 0x06. If the gate is open, it also drives `reset_req` high, and `reset_req` stays high until `rst_n` is asserted.
- R7: A reload between two expiries returns the machine to CLEAN, so the next expiry counts as a first one.
- R8: Writing 1 to offset 0x0C bit 0 always closes the gate. Writing 0 opens it only while `strap_noreboot` is low; otherwise the bit reads back as 1. While the gate is closed, a second expiry returns the machine to CLEAN without requesting a reset.
- R9: The status bits are write-1-to-clear. Writing 3 to offset 0x06 clears its two low bits, and writing 0x0008 to offset 0x04 clears the first-expiry flag.
- R10: Unmapped offsets read 0 and ignore writes. This includes the init offset of the generation that is not selected.
- R11: Read data appears on `rdata` on the clock after the `rd_en` cycle, and it holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for one cycle |
| rd_en | input | 1 | Read strobe for one cycle |
| addr | input | 5 | Byte offset in the register window |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Registered read data |
| strap_noreboot | input | 1 | Board strap that forbids opening the no-reboot gate |
| reset_req | output | 1 | Held system reset request |

## Verification
The bench builds the wide generation with `TICK_CYCLES` set to 4. With that setting a whole expiry period of an initial value of 4 takes only 20 clocks, so first expiries, second expiries, gated second expiries and the reload that lies between them all fall within a few hundred cycles. The wide setting also exercises the 6 preserved bits above the 10-bit field, and it makes the narrow init offset 0x01 an unmapped address that can be probed. The narrow generation uses the same model through its parameters and is reached by changing `WIDE`.

// File: rtl/dew_pkg.sv
package dew_pkg;
    typedef enum logic [1:0] {
        ST_CLEAN   = 2'd0,
        ST_ARMED   = 2'd1,
        ST_TRIPPED = 2'd2
    } wdt_stage_e;

    localparam logic [4:0] OFS_COUNT  = 5'h00;
    localparam logic [4:0] OFS_INIT_N = 5'h01;
    localparam logic [4:0] OFS_STAT_A = 5'h04;
    localparam logic [4:0] OFS_STAT_B = 5'h06;
    localparam logic [4:0] OFS_CTRL   = 5'h08;
    localparam logic [4:0] OFS_GATE   = 5'h0C;
    localparam logic [4:0] OFS_INIT_W = 5'h12;

    localparam int HALT_BIT   = 11;
    localparam int FIRST_BIT  = 3;
    localparam int SECOND_BIT = 1;
    localparam int GATE_BIT   = 0;
    localparam int MIN_INIT   = 4;
endpackage

// File: rtl/dew_prescaler.sv
module dew_prescaler #(
    parameter int TICK_CYCLES = 30_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int PW = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1;
    localparam logic [PW-1:0] LAST = PW'(TICK_CYCLES - 1);

    logic [PW-1:0] div_q;

    // Held at zero while halted, so a resumed timer waits a full period.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q <= '0;
        end else if (!run || div_q == LAST) begin
            div_q <= '0;
        end else begin
            div_q <= div_q + 1'b1;
        end
    end

    assign tick = run && (div_q == LAST);
endmodule

// File: rtl/dew_timer.sv
module dew_timer
    import dew_pkg::*;
#(
    parameter int TW = 10,
    parameter logic [TW-1:0] RST_INIT = '1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          reload,
    input  logic [TW-1:0] init_val,
    input  logic          noreboot,
    output logic [TW-1:0] count,
    output logic          first_exp,
    output logic          second_exp,
    output logic          reset_req
);
    wdt_stage_e    st_q, st_d;
    logic [TW-1:0] cnt_q;
    logic          expire;

    // A reload in the same cycle beats an expiry.
    assign expire = tick && !reload && (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= ST_CLEAN;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_CLEAN: begin
                if (!reload && expire) begin
                    st_d = ST_ARMED;                            // first_expiry
                end
            end
            ST_ARMED: begin
                if (reload) begin
                    st_d = ST_CLEAN;                            // reload_clear
                end else if (expire) begin
                    st_d = noreboot ? ST_CLEAN : ST_TRIPPED;    // gated / trip
                end
            end
            ST_TRIPPED: st_d = ST_TRIPPED;
            default:    st_d = ST_CLEAN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= RST_INIT;
        end else if (reload || expire) begin
            cnt_q <= init_val;
        end else if (tick) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    always_comb begin
        first_exp  = expire && (st_q == ST_CLEAN);
        second_exp = expire && (st_q == ST_ARMED);
        reset_req  = (st_q == ST_TRIPPED);
        count      = cnt_q;
    end
endmodule

// File: rtl/dew_regs.sv
module dew_regs
    import dew_pkg::*;
#(
    parameter bit WIDE = 1'b1,
    parameter int TW = 10,
    parameter logic [TW-1:0] RST_INIT = '1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic          rd_en,
    input  logic [4:0]    addr,
    input  logic [15:0]   wdata,
    input  logic          strap_noreboot,
    input  logic [TW-1:0] count,
    input  logic          first_exp,
    input  logic          second_exp,
    output logic [15:0]   rdata,
    output logic          halt,
    output logic          noreboot,
    output logic          reload,
    output logic [TW-1:0] init_val
);
    localparam int         RW       = WIDE ? 16 : 8;
    localparam int         SW       = RW - TW;
    localparam logic [4:0] INIT_OFS = WIDE ? OFS_INIT_W : OFS_INIT_N;

    logic [TW-1:0] init_q;
    logic [SW-1:0] spare_q;
    logic          halt_q, gate_q, stat_a_q, stat_b_q;
    logic [15:0]   rd_mux, rdata_q;
    logic          wr_init, wr_ctrl, wr_gate, wr_stat_a, wr_stat_b, init_ok;
    logic          unused_bits;

    assign unused_bits = ^wdata;

    assign reload    = wr_en && (addr == OFS_COUNT);
    assign wr_init   = wr_en && (addr == INIT_OFS);
    assign wr_ctrl   = wr_en && (addr == OFS_CTRL);
    assign wr_gate   = wr_en && (addr == OFS_GATE);
    assign wr_stat_a = wr_en && (addr == OFS_STAT_A);
    assign wr_stat_b = wr_en && (addr == OFS_STAT_B);
    assign init_ok   = wdata[TW-1:0] >= TW'(MIN_INIT);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            init_q   <= RST_INIT;
            spare_q  <= '0;
            halt_q   <= 1'b1;
            gate_q   <= 1'b1;
            stat_a_q <= 1'b0;
            stat_b_q <= 1'b0;
        end else begin
            if (wr_init) begin
                spare_q <= wdata[RW-1:TW];
                if (init_ok) begin
                    init_q <= wdata[TW-1:0];
                end
            end
            if (wr_ctrl) begin
                halt_q <= wdata[HALT_BIT];
            end
            if (wr_gate) begin
                if (wdata[GATE_BIT]) begin
                    gate_q <= 1'b1;
                end else if (!strap_noreboot) begin
                    gate_q <= 1'b0;
                end
            end
            if (first_exp) begin
                stat_a_q <= 1'b1;
            end else if (wr_stat_a && wdata[FIRST_BIT]) begin
                stat_a_q <= 1'b0;
            end
            if (second_exp) begin
                stat_b_q <= 1'b1;
            end else if (wr_stat_b && wdata[SECOND_BIT]) begin
                stat_b_q <= 1'b0;
            end
        end
    end

    always_comb begin
        rd_mux = '0;
        case (addr)
            OFS_COUNT:  rd_mux = 16'(count);
            INIT_OFS:   rd_mux = 16'({spare_q, init_q});
            OFS_STAT_A: rd_mux[FIRST_BIT]  = stat_a_q;
            OFS_STAT_B: rd_mux[SECOND_BIT] = stat_b_q;
            OFS_CTRL:   rd_mux[HALT_BIT]   = halt_q;
            OFS_GATE:   rd_mux[GATE_BIT]   = gate_q;
            default:    rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (rd_en) begin
            rdata_q <= rd_mux;
        end
    end

    assign rdata    = rdata_q;
    assign halt     = halt_q;
    assign noreboot = gate_q;
    assign init_val = init_q;
endmodule

// File: rtl/dual_expiry_wdt.sv
module dual_expiry_wdt
    import dew_pkg::*;
#(
    parameter bit WIDE        = 1'b1,
    parameter int TICK_CYCLES = 30_000_000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic        rd_en,
    input  logic [4:0]  addr,
    input  logic [15:0] wdata,
    output logic [15:0] rdata,
    input  logic        strap_noreboot,
    output logic        reset_req
);
    localparam int TW = WIDE ? 10 : 6;
    localparam logic [TW-1:0] RST_INIT = '1;

    logic          tick, halt, noreboot, reload, first_exp, second_exp;
    logic [TW-1:0] init_val, count;

    dew_prescaler #(.TICK_CYCLES(TICK_CYCLES)) u_pre (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (!halt),
        .tick (tick)
    );

    dew_timer #(.TW(TW), .RST_INIT(RST_INIT)) u_tmr (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .reload    (reload),
        .init_val  (init_val),
        .noreboot  (noreboot),
        .count     (count),
        .first_exp (first_exp),
        .second_exp(second_exp),
        .reset_req (reset_req)
    );

    dew_regs #(.WIDE(WIDE), .TW(TW), .RST_INIT(RST_INIT)) u_regs (
        .clk           (clk),
        .rst_n         (rst_n),
        .wr_en         (wr_en),
        .rd_en         (rd_en),
        .addr          (addr),
        .wdata         (wdata),
        .strap_noreboot(strap_noreboot),
        .count         (count),
        .first_exp     (first_exp),
        .second_exp    (second_exp),
        .rdata         (rdata),
        .halt          (halt),
        .noreboot      (noreboot),
        .reload        (reload),
        .init_val      (init_val)
    );
endmodule

// File: rtl/dew_checker.sv
module dew_checker #(
    parameter int TW = 10
) (
    input logic          clk,
    input logic          rst_n,
    input logic          reset_req,
    input logic          noreboot,
    input logic          strap_noreboot,
    input logic          halt,
    input logic          reload,
    input logic [TW-1:0] count
);
    // R6
    reset_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reset_req |=> reset_req);

    // R8
    gate_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(reset_req) |-> $past(!noreboot));

    // R8
    strap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (strap_noreboot && noreboot) |=> noreboot);

    // R2
    halt_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (halt && !reload) |=> $stable(count));

    // R2
    single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!reload && count != '0) |=> (count == $past(count) || count == $past(count) - 1'b1));
endmodule

bind dual_expiry_wdt dew_checker #(.TW(TW)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .reset_req     (reset_req),
    .noreboot      (noreboot),
    .strap_noreboot(strap_noreboot),
    .halt          (halt),
    .reload        (reload),
    .count         (count)
);

// File: tb/dual_expiry_wdt_test.sv
module dual_expiry_wdt_test;
    localparam bit WIDE     = 1'b1;
    localparam int TICK     = 4;
    localparam int TW       = WIDE ? 10 : 6;
    localparam int RW       = WIDE ? 16 : 8;
    localparam int TMASK    = (1 << TW) - 1;
    localparam int SMASK    = (1 << (RW - TW)) - 1;
    localparam int INIT_OFS = WIDE ? 18 : 1;
    localparam int ALT_OFS  = WIDE ? 1 : 18;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [4:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic        strap_noreboot = 1'b0;
    logic [15:0] rdata;
    logic        reset_req;

    int compared = 0;
    int mismatched = 0;
    int cyc = 0;
    bit done = 1'b0;

    // behavioural reference state
    int m_cnt, m_init, m_spare, m_halt, m_gate, m_sta, m_stb, m_stage, m_pre, m_rdata;
    int t_tick, t_reload, t_exp, t_first, t_second;

    dual_expiry_wdt #(.WIDE(WIDE), .TICK_CYCLES(TICK)) uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .strap_noreboot(strap_noreboot), .reset_req(reset_req)
    );

    always #10 clk = ~clk;

    function automatic int mread(input int a);
        if (a == 0) return m_cnt;
        if (a == INIT_OFS) return (m_spare << TW) | m_init;
        if (a == 4) return m_sta << 3;
        if (a == 6) return m_stb << 1;
        if (a == 8) return m_halt << 11;
        if (a == 12) return m_gate;
        return 0;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = TMASK; m_init = TMASK; m_spare = 0; m_halt = 1; m_gate = 1;
            m_sta = 0; m_stb = 0; m_stage = 0; m_pre = 0; m_rdata = 0;
        end else begin
            t_tick   = (m_halt == 0 && m_pre == TICK - 1) ? 1 : 0;
            t_reload = (wr_en && addr == 0) ? 1 : 0;
            t_exp    = (t_tick == 1 && t_reload == 0 && m_cnt == 0) ? 1 : 0;
            t_first  = (t_exp == 1 && m_stage == 0) ? 1 : 0;
            t_second = (t_exp == 1 && m_stage == 1) ? 1 : 0;
            if (rd_en) m_rdata = mread(int'(addr));
            if (m_halt == 1 || m_pre == TICK - 1) m_pre = 0; else m_pre = m_pre + 1;
            if (t_reload == 1) begin
                m_cnt = m_init;
                if (m_stage != 2) m_stage = 0;
            end else if (t_exp == 1) begin
                m_cnt = m_init;
                if (m_stage == 0) m_stage = 1;
                else if (m_stage == 1) m_stage = (m_gate == 1) ? 0 : 2;
            end else if (t_tick == 1) begin
                m_cnt = m_cnt - 1;
            end
            if (wr_en && int'(addr) == INIT_OFS) begin
                m_spare = (int'(wdata) >> TW) & SMASK;
                if ((int'(wdata) & TMASK) >= 4) m_init = int'(wdata) & TMASK;
            end
            if (wr_en && addr == 8) m_halt = int'(wdata[11]);
            if (wr_en && addr == 12) begin
                if (wdata[0]) m_gate = 1;
                else if (!strap_noreboot) m_gate = 0;
            end
            if (t_first == 1) m_sta = 1;
            else if (wr_en && addr == 4 && wdata[3]) m_sta = 0;
            if (t_second == 1) m_stb = 1;
            else if (wr_en && addr == 6 && wdata[1]) m_stb = 0;
        end
    end

    // per-clock comparison against the reference
    always @(negedge clk) begin
        if (rst_n && !done) begin
            compared = compared + 2;
            if (reset_req !== (m_stage == 2)) begin
                mismatched++;
                $display("FAIL R6 model reset_req: actual %0b expected %0b", reset_req, m_stage == 2);
            end
            if (rdata !== 16'(m_rdata)) begin
                mismatched++;
                $display("FAIL R11 model rdata: actual %h expected %h", rdata, 16'(m_rdata));
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc == 100000 && !done) begin
            done = 1'b1;
            mismatched++;
            $display("FAIL watchdog all requirements: actual hang expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    task automatic check(input string tag, input int act, input int exp);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk);
        addr = 5'(a); wdata = 16'(d); wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input int a, output int v);
        @(negedge clk);
        addr = 5'(a); rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        v = int'(rdata);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset;
        @(negedge clk);
        rst_n = 1'b0;
        idle(3);
        rst_n = 1'b1;
    endtask

    initial begin
        int v, c1, c2;
        do_reset();
        // R1 reset state
        check("R1 reset_req", int'(reset_req), 0);
        rd(0, v);  check("R1 count", v, TMASK);
        rd(8, v);  check("R1 halted", v, 16'h0800);
        rd(12, v); check("R1 gate", v, 1);
        rd(4, v);  check("R1 stat_a", v, 0);
        rd(6, v);  check("R1 stat_b", v, 0);
        rd(INIT_OFS, v); check("R1 init", v, TMASK);
        // R10 unmapped offsets
        wr(14, 16'hFFFF); rd(14, v); check("R10 unmapped 0x0E", v, 0);
        wr(ALT_OFS, 16'hFFFF); rd(ALT_OFS, v); check("R10 other init offset", v, 0);
        rd(INIT_OFS, v); check("R10 init untouched", v, TMASK);
        rd(8, v); check("R10 ctrl untouched", v, 16'h0800);
        // R4 init field, spare bits, small values ignored
        wr(INIT_OFS, ((SMASK & 5'h0A) << TW) | 5);
        rd(INIT_OFS, v); check("R4 init write", v, ((SMASK & 5'h0A) << TW) | 5);
        wr(INIT_OFS, ((SMASK & 5'h15) << TW) | 3);
        rd(INIT_OFS, v); check("R4 ignore 3", v, ((SMASK & 5'h15) << TW) | 5);
        wr(INIT_OFS, 0);
        rd(INIT_OFS, v); check("R4 ignore 0", v, 5);
        // R3 reload from init
        wr(0, 16'h1234); rd(0, v); check("R3 reload", v, 5);
        // R2 counting and halt
        wr(INIT_OFS, 40); wr(0, 0);
        wr(8, 16'hF7FF); rd(8, v); check("R2 run readback", v, 0);
        idle(40);
        wr(8, 16'hFFFF); rd(8, v); check("R2 halt readback", v, 16'h0800);
        rd(0, c1);
        check("R2 counted down", int'(c1 < 40 && c1 > 25), 1);
        idle(20);
        rd(0, c2); check("R2 halted holds", c2, c1);
        // R8 gate control and strap
        wr(12, 0); rd(12, v); check("R8 gate opens", v, 0);
        strap_noreboot = 1'b1;
        wr(12, 1); wr(12, 0); rd(12, v); check("R8 strap refuses", v, 1);
        strap_noreboot = 1'b0;
        wr(12, 0); rd(12, v); check("R8 gate reopened", v, 0);
        // R5 first expiry, R7 reload, R6 trip
        wr(INIT_OFS, 4); wr(0, 0); wr(8, 0);
        idle(26);
        rd(4, v); check("R5 first flag", v, 8);
        check("R5 no reset", int'(reset_req), 0);
        wr(0, 0);
        idle(26);
        check("R7 reload cleared", int'(reset_req), 0);
        rd(6, v); check("R7 no second", v, 0);
        idle(24);
        check("R6 tripped", int'(reset_req), 1);
        rd(6, v); check("R6 second flag", v, 2);
        // R9 write-1-to-clear
        wr(6, 3); rd(6, v); check("R9 clear 0x06", v, 0);
        wr(4, 8); rd(4, v); check("R9 clear 0x04", v, 0);
        wr(8, 16'h0800); wr(0, 0); idle(10);
        check("R6 held", int'(reset_req), 1);
        do_reset();
        check("R6 cleared by reset", int'(reset_req), 0);
        // R8 closed gate blocks the trip
        wr(INIT_OFS, 4); wr(0, 0); wr(8, 0);
        idle(100);
        check("R8 gated no reset", int'(reset_req), 0);
        rd(6, v); check("R8 second recorded", v, 2);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule